// File: doc/BRIEF.md
# Half to single precision float widener

This block turns a 16-bit IEEE 754 binary16 bit pattern into the 32-bit binary32 pattern that has the same value. Every input class is covered: normal numbers, subnormals, positive and negative zero, infinities and NaNs. Because every binary16 value can be written exactly in binary32, the conversion never rounds.

The datapath contains no selection on input class. The input is first placed in the upper half of a 32-bit word. A leading-zero count of the magnitude part gives the left shift that normalises a subnormal. Two masks then patch the special cases. The infinity/NaN mask comes from an add followed by an arithmetic shift. The zero mask comes from the sign of the magnitude minus one.

A result is registered one clock after its input is presented with `in_valid_i`. The result register only loads when a valid input arrives, so the last result stays visible until the next one.

Top module: `hs_cvt`

## Requirements
- R1: A normal input (exponent field `half_i[14:10]` between 1 and 30) gives the same sign bit, exponent field `single_o[30:23]` equal to the input exponent plus 112, and mantissa field `single_o[22:0]` equal to `half_i[9:0]` shifted left by 13.
- R2: A subnormal input (exponent field 0, mantissa m nonzero, value m·2^-24) gives a normalised binary32 result. If p is the position of the highest set bit of m, the exponent field is p+103 and the mantissa holds the bits of m below p, left-aligned. The internal normalisation shift never exceeds 10 for a nonzero magnitude.
- R3: An input with bits [14:0] zero gives `single_o[31]` equal to `half_i[15]` and `single_o[30:0]` zero.
- R4: An input with exponent field 31 and mantissa 0 gives exponent field 0xFF, mantissa 0 and the input sign.
- R5: An input with exponent field 31 and a nonzero mantissa gives exponent field 0xFF, mantissa `half_i[9:0]` shifted left by 13, and the input sign.
- R6: `out_valid_o` is high in exactly those cycles that follow a clock edge at which `in_valid_i` was high.
- R7: While `in_valid_i` is low, `single_o` keeps its value whatever `half_i` carries.
- R8: While `rst_ni` is low, `out_valid_o` and `single_o` are zero.
- R9: The block converts these fixed values: 0x0710→0x38E20000, 0x311F→0x3E23E000, 0x000F→0x35700000, 0x0000→0x00000000, 0x8000→0x80000000, 0x7C00→0x7F800000, 0xFC00→0xFF800000, 0x7CFF→0x7F9FE000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | `half_i` holds an input to convert |
| half_i | input | 16 | binary16 bit pattern |
| out_valid_o | output | 1 | `single_o` holds a fresh result |
| single_o | output | 32 | binary32 bit pattern |

## Verification
The assertions assume that `in_valid_i` and `half_i` are known, stable values at every rising edge once reset has been released. The latency and hold properties read `half_i` only in cycles where `in_valid_i` is high. The stimulus changes inputs only on falling edges and keeps `in_valid_i` low around the reset release, so no property observes a half-driven input. It visits every one of the 65536 input codes and also inserts idle gaps in which `half_i` changes while `in_valid_i` is low.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int H_W       = 16;
  localparam int H_EXP_W   = 5;
  localparam int H_MAN_W   = 10;
  localparam int S_W       = 32;
  localparam int S_EXP_W   = 8;
  localparam int S_MAN_W   = 23;
  localparam int H_BIAS    = (1 << (H_EXP_W - 1)) - 1;
  localparam int S_BIAS    = (1 << (S_EXP_W - 1)) - 1;
  localparam int BIAS_DIFF = S_BIAS - H_BIAS;
  localparam int CLZ_W     = $clog2(S_W + 1);
  localparam int ALIGN_SH  = S_EXP_W - H_EXP_W;
  // adding one at the LSB of the wide-word exponent field carries into bit 31 only for exponent all-ones
  localparam logic [S_W-1:0] INF_INC    = S_W'(1) << (S_W - 1 - H_EXP_W);
  localparam logic [S_W-1:0] S_EXP_MASK = S_W'((1 << S_EXP_W) - 1) << S_MAN_W;
  localparam logic [S_W-1:0] MAG_MASK   = ~(S_W'(1) << (S_W - 1));
endpackage

// File: rtl/hs_lzc.sv
module hs_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/hs_masks.sv
module hs_masks
  import hs_pkg::*;
(
  input  logic [S_W-1:0] mag_i,
  output logic [S_W-1:0] infnan_o,
  output logic [S_W-1:0] zero_o
);
  logic [S_W-1:0] sum_w, dec_w, spread_w;

  always_comb begin
    sum_w    = mag_i + INF_INC;
    spread_w = S_W'($signed(sum_w) >>> S_EXP_W);
    infnan_o = spread_w & S_EXP_MASK;
    dec_w    = mag_i - S_W'(1);
    zero_o   = S_W'($signed(dec_w) >>> (S_W - 1));
  end
endmodule

// File: rtl/hs_pack.sv
module hs_pack
  import hs_pkg::*;
(
  input  logic [S_W-1:0]   sign_i,
  input  logic [S_W-1:0]   mag_i,
  input  logic [CLZ_W-1:0] shift_i,
  input  logic [S_W-1:0]   infnan_i,
  input  logic [S_W-1:0]   zero_i,
  output logic [S_W-1:0]   res_o
);
  logic [S_W-1:0] norm_w, exp_adj_w, body_w;

  always_comb begin
    norm_w    = (mag_i << shift_i) >> ALIGN_SH;
    exp_adj_w = (S_W'(BIAS_DIFF) - S_W'(shift_i)) << S_MAN_W;
    body_w    = ((norm_w + exp_adj_w) | infnan_i) & ~zero_i;
    res_o     = sign_i | body_w;
  end
endmodule

// File: rtl/hs_cvt.sv
module hs_cvt
  import hs_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic [H_W-1:0] half_i,
  output logic           out_valid_o,
  output logic [S_W-1:0] single_o
);
  logic [S_W-1:0]   word_w, sign_w, mag_w;
  logic [CLZ_W-1:0] clz_w, shift_w;
  logic [S_W-1:0]   infnan_w, zero_w, res_w;

  assign word_w = {half_i, {(S_W - H_W){1'b0}}};
  assign sign_w = word_w & ~MAG_MASK;
  assign mag_w  = word_w & MAG_MASK;

  hs_lzc #(.W(S_W), .CW(CLZ_W)) u_lzc (
    .vec_i (mag_w),
    .cnt_o (clz_w)
  );

  // only subnormals push the leading one past the exponent field
  assign shift_w = (clz_w > CLZ_W'(H_EXP_W)) ? clz_w - CLZ_W'(H_EXP_W) : '0;

  hs_masks u_masks (
    .mag_i    (mag_w),
    .infnan_o (infnan_w),
    .zero_o   (zero_w)
  );

  hs_pack u_pack (
    .sign_i   (sign_w),
    .mag_i    (mag_w),
    .shift_i  (shift_w),
    .infnan_i (infnan_w),
    .zero_i   (zero_w),
    .res_o    (res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      single_o    <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) single_o <= res_w;
    end
  end

  p_shift_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_w != '0) |-> (shift_w <= CLZ_W'(H_MAN_W)));

  p_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && half_i[H_W-2:0] == '0) |=>
      (single_o[S_W-2:0] == '0 && single_o[S_W-1] == $past(half_i[H_W-1])));

  p_infnan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (&half_i[H_W-2:H_MAN_W])) |=> (&single_o[S_W-2:S_MAN_W]));

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_valid_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(single_o));
endmodule

// File: tb/hs_cvt_test.sv
`timescale 1ns/1ps
module hs_cvt_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] half_in = '0;
  logic        out_valid;
  logic [31:0] single_out;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  hs_cvt uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .half_i      (half_in),
    .out_valid_o (out_valid),
    .single_o    (single_out)
  );

  function automatic logic [31:0] ref_cvt(input logic [15:0] h);
    logic [4:0] e;
    logic [9:0] m;
    logic [9:0] frac;
    int p;
    e = h[14:10];
    m = h[9:0];
    if (e == 0 && m == 0) return {h[15], 31'd0};
    if (e == 31) return {h[15], 8'hFF, m, 13'd0};
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 10; i++) if (m[i]) p = i;
      frac = m << (10 - p);
      return {h[15], 8'(p + 103), frac, 13'd0};
    end
    return {h[15], 8'(e + 112), m, 13'd0};
  endfunction

  function automatic string class_tag(input logic [15:0] h);
    if (h[14:0] == 0) return "R3";
    if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R4" : "R5";
    if (h[14:10] == 5'd0) return "R2";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] h, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    half_in  = h;
    exp_q.push_back(ref_cvt(h));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n, input logic [15:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      half_in  = junk ^ 16'(i);
    end
  endtask

  // monitor: pop one expected item per valid output
  always @(negedge clk) begin
    if (rst_ni && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R6", 32'(out_valid), 32'd0);
      end else begin
        string t;
        logic [31:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, single_out, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R8", 32'(out_valid), 32'd0);
    check("R8", single_out, 32'd0);
    rst_ni = 1'b1;
    idle(2, 16'h1234);

    // R9 fixed values, with expected numbers spelled out
    send(16'h0710, "R9"); if (ref_cvt(16'h0710) != 32'h38E20000) check("R9", ref_cvt(16'h0710), 32'h38E20000);
    send(16'h311F, "R9");
    send(16'h000F, "R9"); if (ref_cvt(16'h000F) != 32'h35700000) check("R9", ref_cvt(16'h000F), 32'h35700000);
    send(16'h0000, "R9");
    send(16'h8000, "R9");
    send(16'h7C00, "R9");
    send(16'hFC00, "R9");
    send(16'h7CFF, "R9"); if (ref_cvt(16'h7CFF) != 32'h7F9FE000) check("R9", ref_cvt(16'h7CFF), 32'h7F9FE000);

    // R7: hold while idle, half_i wiggling
    send(16'h3C00, "R1");
    @(negedge clk);
    in_valid = 1'b0;
    half_in  = 16'h7C00;
    held = 32'h3F800000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      half_in = 16'hFC01 + 16'(i);
      check("R7", single_out, held);
      check("R6", 32'(out_valid), 32'd0);
    end

    // R6: isolated pulses
    for (int i = 0; i < 3; i++) begin
      send(16'h0001 << i, "R2");
      idle(2, 16'h5555);
      check("R6", 32'(out_valid), 32'd0);
    end

    // full sweep, back to back
    for (int v = 0; v < 65536; v++) send(16'(v), class_tag(16'(v)));
    idle(4, 16'hAAAA);
    check("R6", 32'(exp_q.size()), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule